// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of programmable hardware triggers and checks every instruction fetch, load and store against all of them in the same cycle. Each trigger keeps a control word and a compare value. The control word chooses which accesses and privilege levels the trigger watches and whether it looks at the access address or the access data. It also sets the comparison mode, whether the trigger links with the next one, and the action code that is reported when it fires. The match path is purely combinational. Its result is a hit flag, the index of the reporting trigger and that trigger's action code.

Configuration goes through a single synchronous write port. Each write updates either one trigger's control word or its compare value. Carrying out the reported action, such as halting or tracing, is left to the surrounding core. While the hart is already halted in debug mode, the unit reports nothing.

Top module: `trig_match_unit`

## Requirements
- R1: Triggers are evaluated from index 0 upward. When several triggers fire on one access, the lowest index that completes a match is reported.
- R2: While `in_debug` is high, `hit` is 0, whatever the configuration and access.
- R3: A trigger takes part only if its enable for the access type is set. The access type is `acc_op`: 0 = fetch, 1 = load, 2 = store, and 3 = no access, which never matches.
- R4: A trigger takes part only if its enable for the current privilege level is set. The level is `acc_priv`: 0 = user, 1 = supervisor, 2 = hypervisor, 3 = machine.
- R5: When the select bit is set, the trigger compares `acc_data`. When the select bit is clear, it compares `acc_addr`.
- R6: Mode 0 (exact) matches only when the value equals the compare value.
- R7: Mode 1 (aligned range) counts n, the number of consecutive ones from bit 0 of the compare value. It then ignores the low n bits of both operands and compares the rest. A compare value of all ones matches any value.
- R8: Mode 2 matches when value >= compare, and mode 3 matches when value < compare. Both comparisons are unsigned.
- R9: Modes 4 and 5 take a mask equal to the compare value shifted right by H bits. H is XLEN/2, or 16 in 32-bit mode. Mode 4 matches when (value & mask) == (compare & mask). Mode 5 does the same test on (value >> H).
- R10: Mode codes 6 to 15 never match.
- R11: A trigger with its link bit set never reports on its own. A linked group reports at its last member (link bit clear) only if every member matches. After a failing member, the later members of the same group are skipped. Evaluation restarts after the first member whose link bit is clear. A group still open at the last trigger never reports.
- R12: When `mode32` is high, only the low 32 bits of the compared value are used. The upper bits are treated as zero.
- R13: On a hit, `hit_action` carries the firing trigger's 3-bit action code (0 debug exception, 1 enter debug mode, 2 trace start, 3 trace stop, 4 trace emit). With no hit, `hit_idx` and `hit_action` are 0.
- R14: A write with `cfg_sel` = 0 loads `cfg_wdata[15:0]` into the control word of trigger `cfg_idx`. A write with `cfg_sel` = 1 loads the compare value. The new value takes effect after the clock edge. Reset clears every control word and compare value, so no trigger fires. Control word layout: bit 0 fetch, bit 1 load, bit 2 store, bits 3..6 user/supervisor/hypervisor/machine enables, bit 7 select, bits 11:8 mode, bit 12 link, bits 15:13 action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NTRIG) | Trigger addressed by the write |
| cfg_sel | input | 1 | 0 = control word, 1 = compare value |
| cfg_wdata | input | XLEN | Write data |
| acc_op | input | 2 | Access type of the current access |
| acc_priv | input | 2 | Current privilege level |
| acc_addr | input | XLEN | Access address or fetch PC |
| acc_data | input | XLEN | Access data |
| mode32 | input | 1 | 32-bit mode: truncate compared value |
| in_debug | input | 1 | Hart is already in debug mode |
| hit | output | 1 | A trigger fired |
| hit_idx | output | $clog2(NTRIG) | Index of the firing trigger |
| hit_action | output | 3 | Action code of the firing trigger |

## Verification
The bench builds the unit with its defaults: four triggers and XLEN = 64. Four triggers are enough for a two-member linked group plus a trailing group left open at the last index. A 64-bit width makes the 32-bit truncation visible on sign-extended addresses. It also puts the split-word mask modes at their natural 32-bit half, so the ignored upper half of a mask-low operand can be exercised.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  localparam int CTRL_W = 16;

  // access kinds
  localparam logic [1:0] OP_FETCH = 2'd0;
  localparam logic [1:0] OP_LOAD  = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;

  // comparison modes
  localparam logic [3:0] MM_EQ    = 4'd0;
  localparam logic [3:0] MM_NAPOT = 4'd1;
  localparam logic [3:0] MM_GE    = 4'd2;
  localparam logic [3:0] MM_LT    = 4'd3;
  localparam logic [3:0] MM_MLO   = 4'd4;
  localparam logic [3:0] MM_MHI   = 4'd5;

  // control word, MSB first: action, link, mode, select, privilege enables, op enables
  typedef struct packed {
    logic [2:0] act;
    logic       link;
    logic [3:0] mode;
    logic       sel_data;
    logic [3:0] priv_en;
    logic [2:0] op_en;
  } tmu_ctrl_t;

endpackage

// File: rtl/tmu_cfg_regs.sv
module tmu_cfg_regs
  import tmu_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 64,
  localparam int IW   = $clog2(NTRIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic            sel,
  input  logic [XLEN-1:0] wdata,
  output tmu_ctrl_t       ctrl_q [NTRIG],
  output logic [XLEN-1:0] cmp_q  [NTRIG]
);

  logic [NTRIG-1:0] ctrl_en;
  logic [NTRIG-1:0] cmp_en;
  tmu_ctrl_t        ctrl_d;

  always_comb begin
    ctrl_d = tmu_ctrl_t'(wdata[CTRL_W-1:0]);
    for (int i = 0; i < NTRIG; i++) begin
      ctrl_en[i] = we && !sel && (idx == IW'(i));
      cmp_en[i]  = we &&  sel && (idx == IW'(i));
    end
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        cmp_q[g]  <= '0;
      end else begin
        if (ctrl_en[g]) ctrl_q[g] <= ctrl_d;
        if (cmp_en[g])  cmp_q[g]  <= wdata;
      end
    end
  end

endmodule

// File: rtl/tmu_cmp.sv
module tmu_cmp
  import tmu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic [2:0]      op_en,
  input  logic [3:0]      priv_en,
  input  logic            sel_data,
  input  logic [3:0]      mode,
  input  logic [XLEN-1:0] cmp,
  input  logic [1:0]      op,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] data,
  input  logic            mode32,
  output logic            pass
);

  logic [3:0]      op_vec;
  logic            elig;
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] val;
  logic [XLEN-1:0] keep;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] val_hi;
  logic            run;
  logic            cmp_ok;

  always_comb begin
    op_vec = {1'b0, op_en};
    elig   = op_vec[op] && priv_en[priv];
    raw    = sel_data ? data : addr;
    val    = mode32 ? {{(XLEN-32){1'b0}}, raw[31:0]} : raw;

    // bits below the first zero of the compare value are ignored
    run = 1'b1;
    for (int k = 0; k < XLEN; k++) begin
      run     = run & cmp[k];
      keep[k] = ~run;
    end

    mask   = mode32 ? (cmp >> 16) : (cmp >> HALF);
    val_hi = mode32 ? (val >> 16) : (val >> HALF);

    unique case (mode)
      MM_EQ:    cmp_ok = (val == cmp);
      MM_NAPOT: cmp_ok = ((val & keep) == (cmp & keep));
      MM_GE:    cmp_ok = (val >= cmp);
      MM_LT:    cmp_ok = (val <  cmp);
      MM_MLO:   cmp_ok = ((val & mask) == (cmp & mask));
      MM_MHI:   cmp_ok = ((val_hi & mask) == (cmp & mask));
      default:  cmp_ok = 1'b0;
    endcase

    pass = elig && cmp_ok;
  end

endmodule

// File: rtl/tmu_pick.sv
module tmu_pick #(
  parameter int NTRIG = 4,
  localparam int IW   = $clog2(NTRIG)
) (
  input  logic [NTRIG-1:0]      pass_i,
  input  logic [NTRIG-1:0]      link_i,
  input  logic [NTRIG-1:0][2:0] act_i,
  input  logic                  in_debug,
  output logic                  hit,
  output logic [IW-1:0]         hit_idx,
  output logic [2:0]            hit_action
);

  logic          group_ok;
  logic          found;
  logic [IW-1:0] sel_idx;
  logic [2:0]    sel_act;

  always_comb begin
    group_ok = 1'b1;
    found    = 1'b0;
    sel_idx  = '0;
    sel_act  = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (!found) begin
        if (!group_ok || !pass_i[i]) begin
          // skip or fail: a member with link clear closes the group
          group_ok = !link_i[i];
        end else if (!link_i[i]) begin
          found   = 1'b1;
          sel_idx = IW'(i);
          sel_act = act_i[i];
        end
      end
    end
    hit        = found && !in_debug;
    hit_idx    = hit ? sel_idx : '0;
    hit_action = hit ? sel_act : '0;
  end

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import tmu_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 64,
  localparam int IW   = $clog2(NTRIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic            cfg_sel,
  input  logic [XLEN-1:0] cfg_wdata,
  input  logic [1:0]      acc_op,
  input  logic [1:0]      acc_priv,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [XLEN-1:0] acc_data,
  input  logic            mode32,
  input  logic            in_debug,
  output logic            hit,
  output logic [IW-1:0]   hit_idx,
  output logic [2:0]      hit_action
);

  tmu_ctrl_t                ctrl_q [NTRIG];
  logic [XLEN-1:0]          cmp_q  [NTRIG];
  logic [NTRIG-1:0]         pass;
  logic [NTRIG-1:0]         link;
  logic [NTRIG-1:0][2:0]    act;
  logic [NTRIG*CTRL_W-1:0]  ctrl_flat;

  tmu_cfg_regs #(.NTRIG(NTRIG), .XLEN(XLEN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .ctrl_q (ctrl_q),
    .cmp_q  (cmp_q)
  );

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    tmu_cmp #(.XLEN(XLEN)) u_cmp (
      .op_en    (ctrl_q[g].op_en),
      .priv_en  (ctrl_q[g].priv_en),
      .sel_data (ctrl_q[g].sel_data),
      .mode     (ctrl_q[g].mode),
      .cmp      (cmp_q[g]),
      .op       (acc_op),
      .priv     (acc_priv),
      .addr     (acc_addr),
      .data     (acc_data),
      .mode32   (mode32),
      .pass     (pass[g])
    );
    assign link[g] = ctrl_q[g].link;
    assign act[g]  = ctrl_q[g].act;
    assign ctrl_flat[g*CTRL_W +: CTRL_W] = ctrl_q[g];
  end

  tmu_pick #(.NTRIG(NTRIG)) u_pick (
    .pass_i     (pass),
    .link_i     (link),
    .act_i      (act),
    .in_debug   (in_debug),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .hit_action (hit_action)
  );

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
  parameter int NTRIG = 4,
  parameter int CW    = 16,
  localparam int IW   = $clog2(NTRIG)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [IW-1:0]       cfg_idx,
  input logic                cfg_sel,
  input logic [CW-1:0]       cfg_lo,
  input logic [1:0]          acc_op,
  input logic [1:0]          acc_priv,
  input logic                in_debug,
  input logic                hit,
  input logic [IW-1:0]       hit_idx,
  input logic [2:0]          hit_action,
  input logic [NTRIG*CW-1:0] ctrl_flat
);

  logic [IW-1:0] last_idx;
  logic [CW-1:0] fired_ctrl;
  logic [CW-1:0] wr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= cfg_idx;
  end

  always_comb begin
    fired_ctrl = ctrl_flat[hit_idx*CW +: CW];
    wr_slot    = ctrl_flat[last_idx*CW +: CW];
  end

  assert_quiet_in_debug_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug |-> !hit);

  assert_op_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_op != 2'd3) && fired_ctrl[acc_op]);

  assert_priv_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> fired_ctrl[4'(acc_priv) + 4'd3]);

  assert_known_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (fired_ctrl[11:8] <= 4'd5));

  assert_no_open_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !fired_ctrl[12]);

  assert_action_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_action == fired_ctrl[15:13]));

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0) && (hit_action == 3'd0));

  assert_ctrl_write_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (wr_slot == $past(cfg_lo)));

endmodule

bind trig_match_unit tmu_checker #(.NTRIG(NTRIG), .CW(tmu_pkg::CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_sel    (cfg_sel),
  .cfg_lo     (cfg_wdata[tmu_pkg::CTRL_W-1:0]),
  .acc_op     (acc_op),
  .acc_priv   (acc_priv),
  .in_debug   (in_debug),
  .hit        (hit),
  .hit_idx    (hit_idx),
  .hit_action (hit_action),
  .ctrl_flat  (ctrl_flat)
);

// File: tb/tb_trig_match_unit.sv
module tb_trig_match_unit;

  localparam int NTRIG = 4;
  localparam int XLEN  = 64;
  localparam int IW    = $clog2(NTRIG);

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic [IW-1:0]   cfg_idx;
  logic            cfg_sel;
  logic [XLEN-1:0] cfg_wdata;
  logic [1:0]      acc_op;
  logic [1:0]      acc_priv;
  logic [XLEN-1:0] acc_addr;
  logic [XLEN-1:0] acc_data;
  logic            mode32;
  logic            in_debug;
  logic            hit;
  logic [IW-1:0]   hit_idx;
  logic [2:0]      hit_action;

  int n_cmp;
  int n_bad;

  trig_match_unit #(.NTRIG(NTRIG), .XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_op(acc_op),
    .acc_priv(acc_priv), .acc_addr(acc_addr), .acc_data(acc_data),
    .mode32(mode32), .in_debug(in_debug), .hit(hit), .hit_idx(hit_idx),
    .hit_action(hit_action)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  priv;
    logic [63:0] addr;
    logic [63:0] data;
    logic        r32;
    logic        dbg;
    logic        ehit;
    logic [1:0]  eidx;
    logic [2:0]  eact;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd3, 64'h1000,                64'h0,    1'b0, 1'b0, 1'b1, 2'd0, 3'd1},
    '{2'd0, 2'd1, 64'h1000,                64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd0, 2'd0, 64'h9000_0000,           64'h0,    1'b0, 1'b0, 1'b1, 2'd2, 3'd3},
    '{2'd1, 2'd3, 64'h0,                   64'h20AB, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2},
    '{2'd1, 2'd3, 64'h0,                   64'h21AB, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd2, 2'd1, 64'hFF,                  64'h2000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2},
    '{2'd2, 2'd1, 64'hFF,                  64'h0,    1'b0, 1'b0, 1'b1, 2'd3, 3'd4},
    '{2'd2, 2'd1, 64'h100,                 64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd0, 2'd3, 64'h1000,                64'h0,    1'b0, 1'b1, 1'b0, 2'd0, 3'd0},
    '{2'd0, 2'd3, 64'hFFFF_FFFF_0000_1000, 64'h0,    1'b1, 1'b0, 1'b1, 2'd0, 3'd1},
    '{2'd0, 2'd3, 64'hFFFF_FFFF_0000_1000, 64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd0, 2'd2, 64'h1000,                64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd0, 2'd0, 64'h7FFF_FFFF,           64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd0, 2'd0, 64'h8000_0000,           64'h0,    1'b0, 1'b0, 1'b1, 2'd2, 3'd3},
    '{2'd2, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd3, 2'd3, 64'h1000,                64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'd1, 2'd3, 64'h1000,                64'h0,    1'b0, 1'b0, 1'b0, 2'd0, 3'd0}
  };

  function automatic string tag_of(int k);
    case (k)
      0:  return "R6";
      1:  return "R4";
      2:  return "R8";
      3:  return "R7";
      4:  return "R7";
      5:  return "R1";
      6:  return "R13";
      7:  return "R8";
      8:  return "R2";
      9:  return "R12";
      10: return "R12";
      11: return "R4";
      12: return "R8";
      13: return "R8";
      14: return "R8";
      15: return "R3";
      default: return "R3";
    endcase
  endfunction

  // control word: act[15:13] link[12] mode[11:8] sel[7] priv[6:3] op[2:0]
  function automatic logic [63:0] mk(input logic [2:0] a, input logic l,
                                     input logic [3:0] m, input logic s,
                                     input logic [3:0] p, input logic [2:0] o);
    return {48'h0, a, l, m, s, p, o};
  endfunction

  task automatic check(input string tag, input logic eh, input logic [IW-1:0] ei,
                       input logic [2:0] ea);
    n_cmp++;
    if (hit !== eh || hit_idx !== ei || hit_action !== ea) begin
      n_bad++;
      $display("FAIL %s: got hit=%0b idx=%0d act=%0d, expected hit=%0b idx=%0d act=%0d",
               tag, hit, hit_idx, hit_action, eh, ei, ea);
    end
  endtask

  task automatic wr(input int idx, input logic sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [1:0] op, input logic [1:0] pv, input logic [63:0] a,
                     input logic [63:0] d, input logic r32, input logic dbg);
    @(negedge clk);
    acc_op = op; acc_priv = pv; acc_addr = a; acc_data = d; mode32 = r32; in_debug = dbg;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1ms;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = 1'b0; cfg_wdata = '0;
    acc_op = 2'd0; acc_priv = 2'd3; acc_addr = '0; acc_data = '0;
    mode32 = 1'b0; in_debug = 1'b0;
    #22;
    @(negedge clk);
    rst_n = 1'b1;

    // R14: after reset every trigger is disabled
    acc(2'd0, 2'd3, 64'h0, 64'h0, 1'b0, 1'b0);
    check("R14", 1'b0, '0, 3'd0);

    // table configuration
    wr(0, 1'b0, mk(3'd1, 1'b0, 4'd0, 1'b0, 4'b1000, 3'b001));
    wr(0, 1'b1, 64'h1000);
    wr(1, 1'b0, mk(3'd2, 1'b0, 4'd1, 1'b1, 4'b1111, 3'b110));
    wr(1, 1'b1, 64'h20FF);
    wr(2, 1'b0, mk(3'd3, 1'b0, 4'd2, 1'b0, 4'b0011, 3'b001));
    wr(2, 1'b1, 64'h8000_0000);
    wr(3, 1'b0, mk(3'd4, 1'b0, 4'd3, 1'b0, 4'b1111, 3'b100));
    wr(3, 1'b1, 64'h100);

    for (int k = 0; k < NV; k++) begin
      acc(TBL[k].op, TBL[k].priv, TBL[k].addr, TBL[k].data, TBL[k].r32, TBL[k].dbg);
      check(tag_of(k), TBL[k].ehit, TBL[k].eidx, TBL[k].eact);
    end

    // R11: linked group 0->1, then independent triggers 2 and 3
    wr(0, 1'b0, mk(3'd0, 1'b1, 4'd0, 1'b0, 4'b1111, 3'b001));
    wr(0, 1'b1, 64'h40);
    wr(1, 1'b0, mk(3'd2, 1'b0, 4'd0, 1'b1, 4'b1111, 3'b001));
    wr(1, 1'b1, 64'h55);
    wr(2, 1'b0, mk(3'd3, 1'b0, 4'd0, 1'b1, 4'b1111, 3'b001));
    wr(2, 1'b1, 64'h55);
    wr(3, 1'b0, mk(3'd1, 1'b0, 4'd0, 1'b0, 4'b1111, 3'b001));
    wr(3, 1'b1, 64'h40);
    acc(2'd0, 2'd3, 64'h40, 64'h55, 1'b0, 1'b0);
    check("R11", 1'b1, 2'd1, 3'd2);
    acc(2'd0, 2'd3, 64'h41, 64'h55, 1'b0, 1'b0);
    check("R11", 1'b1, 2'd2, 3'd3);
    acc(2'd0, 2'd3, 64'h40, 64'h56, 1'b0, 1'b0);
    check("R11", 1'b1, 2'd3, 3'd1);
    wr(3, 1'b0, mk(3'd1, 1'b1, 4'd0, 1'b0, 4'b1111, 3'b001));
    acc(2'd0, 2'd3, 64'h40, 64'h56, 1'b0, 1'b0);
    check("R11", 1'b0, '0, 3'd0);

    // R9: mask modes on trigger 0 alone
    wr(1, 1'b0, 64'h0);
    wr(2, 1'b0, 64'h0);
    wr(3, 1'b0, 64'h0);
    wr(0, 1'b0, mk(3'd2, 1'b0, 4'd4, 1'b0, 4'b1111, 3'b001));
    wr(0, 1'b1, 64'h0000_FF00_0000_1200);
    acc(2'd0, 2'd3, 64'h12AB, 64'h0, 1'b0, 1'b0);
    check("R9", 1'b1, 2'd0, 3'd2);
    acc(2'd0, 2'd3, 64'h13AB, 64'h0, 1'b0, 1'b0);
    check("R9", 1'b0, '0, 3'd0);
    acc(2'd0, 2'd3, 64'hABCD_0000_0000_12FF, 64'h0, 1'b0, 1'b0);
    check("R9", 1'b1, 2'd0, 3'd2);
    wr(0, 1'b0, mk(3'd2, 1'b0, 4'd5, 1'b0, 4'b1111, 3'b001));
    acc(2'd0, 2'd3, 64'h0000_1234_0000_0000, 64'h0, 1'b0, 1'b0);
    check("R9", 1'b1, 2'd0, 3'd2);
    acc(2'd0, 2'd3, 64'h0000_1334_0000_0000, 64'h0, 1'b0, 1'b0);
    check("R9", 1'b0, '0, 3'd0);

    // R7: aligned range extremes
    wr(0, 1'b0, mk(3'd2, 1'b0, 4'd1, 1'b0, 4'b1111, 3'b001));
    wr(0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(2'd0, 2'd3, 64'hDEAD_BEEF_1234_5678, 64'h0, 1'b0, 1'b0);
    check("R7", 1'b1, 2'd0, 3'd2);
    wr(0, 1'b1, 64'h10);
    acc(2'd0, 2'd3, 64'h10, 64'h0, 1'b0, 1'b0);
    check("R7", 1'b1, 2'd0, 3'd2);
    acc(2'd0, 2'd3, 64'h11, 64'h0, 1'b0, 1'b0);
    check("R7", 1'b0, '0, 3'd0);

    // R10: unused mode codes, with exact mode as control
    wr(0, 1'b1, 64'h0);
    wr(0, 1'b0, mk(3'd4, 1'b0, 4'd6, 1'b0, 4'b1111, 3'b001));
    acc(2'd0, 2'd3, 64'h0, 64'h0, 1'b0, 1'b0);
    check("R10", 1'b0, '0, 3'd0);
    wr(0, 1'b0, mk(3'd4, 1'b0, 4'd15, 1'b0, 4'b1111, 3'b001));
    acc(2'd0, 2'd3, 64'h0, 64'h0, 1'b0, 1'b0);
    check("R10", 1'b0, '0, 3'd0);
    wr(0, 1'b0, mk(3'd4, 1'b0, 4'd0, 1'b0, 4'b1111, 3'b001));
    acc(2'd0, 2'd3, 64'h0, 64'h0, 1'b0, 1'b0);
    check("R6", 1'b1, 2'd0, 3'd4);

    // R5: address compare ignores data
    wr(0, 1'b0, mk(3'd1, 1'b0, 4'd0, 1'b0, 4'b1111, 3'b001));
    wr(0, 1'b1, 64'h77);
    acc(2'd0, 2'd3, 64'h0, 64'h77, 1'b0, 1'b0);
    check("R5", 1'b0, '0, 3'd0);
    acc(2'd0, 2'd3, 64'h77, 64'h0, 1'b0, 1'b0);
    check("R5", 1'b1, 2'd0, 3'd1);

    // R14: asynchronous reset clears configuration
    #2;
    rst_n = 1'b0;
    #1;
    check("R14", 1'b0, '0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    acc(2'd0, 2'd3, 64'h77, 64'h0, 1'b0, 1'b0);
    check("R14", 1'b0, '0, 3'd0);

    finish_run();
  end

endmodule